// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits behind a CAN bit-level receiver and decides where each complete, checked frame is kept. Every frame arrives as one single-cycle strobe. It carries the frame's identifier, its extended-format flag, its remote-request flag, its length code and eight data bytes. The block compares the frame against every enabled mailbox at the same time. It writes the frame into the highest-numbered mailbox that accepts it and flags that mailbox as holding unread data.

Software programs each mailbox's identifier filter and its optional per-mailbox acceptance mask through a simple word-addressed register port. It reads stored frames back through the same port and acknowledges them by writing ones into the pending flags. A per-mailbox overwrite-protect bit makes a full mailbox pass the frame down to the next lower accepting mailbox. When an unprotected full mailbox is reused, its lost flag is set and a sticky lost-message interrupt is raised.

Top module: `rxmb_alloc`

## Requirements
- R1: A frame is stored only in a mailbox whose enable bit is set. Among the enabled mailboxes that accept it, the highest-numbered eligible one is chosen.
- R2: With the mask-use bit (identifier word bit 30) clear, the frame's extended flag must equal identifier word bit 31. A standard frame's 11-bit identifier must equal bits 28:18, and an extended frame's 29-bit identifier must equal bits 28:0.
- R3: With the mask-use bit set, a 1 in bits 28:0 of the mailbox's mask word makes that identifier bit a don't-care. A 1 in mask bit 31 makes the extended flag a don't-care, so an all-ones mask accepts every frame.
- R4: Storing a frame has these effects on the chosen mailbox:
  - Identifier word: bit 31 takes the frame's extended flag and bits 28:0 take the identifier (standard frames in bits 28:18 with zeros below). Bits 30:29 are kept.
  - Control word: bits 3:0 take the length code and bit 4 takes the remote flag. The priority field in bits 13:8 is kept.
  - Data words: the frame data port carries byte 0 in bits 63:56. Bytes 0 to 3 go to the low data word, most significant byte first, and bytes 4 to 7 go to the high data word.
- R5: A stored frame sets the mailbox's pending bit. Writing 1 to a pending bit clears it and writing 0 has no effect. A store in the same cycle as a clear of that bit leaves it set.
- R6: A mailbox whose protect bit and pending bit are both set is skipped, and the frame goes to the next lower eligible mailbox. If none remains, the frame is dropped.
- R7: Storing into a mailbox whose pending bit is set (and is not protected) sets its lost bit and the lost-message interrupt flag. Both are cleared by writing 1.
- R8: A frame that no mailbox can take changes no pending, lost, flag, identifier or data state.
- R9: The register address is {region, mailbox, field}. For region 0, the fields are 0 identifier, 1 control, 2 data low, 3 data high and 4 mask. For region 1, the fields are 0 enable, 1 pending, 2 lost, 3 protect and 4 lost flag (bit 0). Read data appears one cycle after the read strobe.
- R10: After reset, every enable, pending, protect, lost, identifier, mask and priority bit is zero and the interrupt flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe of a received frame |
| frm_ext | input | 1 | Frame uses 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier, standard ones in bits 10:0 |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| rx_pend | output | NUM_MBX | Pending bit per mailbox |
| lost_irq | output | 1 | Sticky lost-message interrupt flag |

## Verification
On every cycle, the assertions check four things:
- A store lands only in an enabled, accepting mailbox that is not both protected and pending.
- The pending bit of the chosen mailbox is set one cycle later.
- The interrupt flag rises only after an overwrite of a pending mailbox.
- A refused frame leaves the pending and lost vectors unchanged.

Only the bench's scenarios can show the rest: that the highest eligible mailbox wins over lower ones, the exact identifier, control and data words left in storage, masked and unmasked filtering of both frame formats, and the set-over-clear collision. These are observed through register reads against a behavioural model.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  // mailbox-region field codes
  localparam logic [2:0] F_ID   = 3'd0;
  localparam logic [2:0] F_CTRL = 3'd1;
  localparam logic [2:0] F_DLO  = 3'd2;
  localparam logic [2:0] F_DHI  = 3'd3;
  localparam logic [2:0] F_LAM  = 3'd4;
  // global-region field codes
  localparam logic [2:0] G_EN   = 3'd0;
  localparam logic [2:0] G_PEND = 3'd1;
  localparam logic [2:0] G_LOST = 3'd2;
  localparam logic [2:0] G_PROT = 3'd3;
  localparam logic [2:0] G_FLAG = 3'd4;

  localparam int ID_EXT_BIT = 31;
  localparam int ID_USE_MASK_BIT = 30;
  localparam int STD_ID_LSB = 18;

  // identifier placed as it sits in bits 28:0 of the identifier word
  function automatic logic [28:0] id_field(input logic ext, input logic [28:0] id);
    return ext ? id : {id[10:0], 18'h0};
  endfunction

  // bits of the identifier word that are compared for this frame format
  function automatic logic [28:0] cmp_field(input logic ext);
    return ext ? '1 : {11'h7FF, 18'h0};
  endfunction
endpackage

// File: rtl/rxmb_match.sv
module rxmb_match
  import rxmb_pkg::*;
#(
  parameter int NUM_MBX = 8
) (
  input  logic                     f_ext,
  input  logic [28:0]              f_word,
  input  logic [NUM_MBX-1:0]       en,
  input  logic [NUM_MBX-1:0][31:0] id_w,
  input  logic [NUM_MBX-1:0][31:0] lam_w,
  output logic [NUM_MBX-1:0]       hit
);
  for (genvar g = 0; g < NUM_MBX; g++) begin : g_cmp
    logic        use_mask;
    logic [28:0] care;
    logic        ide_ok;
    logic        id_ok;
    assign use_mask = id_w[g][ID_USE_MASK_BIT];
    assign care     = cmp_field(f_ext) & (use_mask ? ~lam_w[g][28:0] : '1);
    assign ide_ok   = (use_mask && lam_w[g][31]) || (id_w[g][ID_EXT_BIT] == f_ext);
    assign id_ok    = ((f_word ^ id_w[g][28:0]) & care) == '0;
    assign hit[g]   = en[g] & ide_ok & id_ok;
  end
endmodule

// File: rtl/rxmb_select.sv
module rxmb_select #(
  parameter int NUM_MBX = 8,
  parameter int IW      = $clog2(NUM_MBX)
) (
  input  logic [NUM_MBX-1:0] hit,
  input  logic [NUM_MBX-1:0] pend,
  input  logic [NUM_MBX-1:0] prot,
  output logic               sel_vld,
  output logic [IW-1:0]      sel_idx,
  output logic               sel_over
);
  logic [NUM_MBX-1:0] elig;
  assign elig = hit & ~(prot & pend);

  // later iterations win, so the highest eligible index is kept
  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NUM_MBX; i++) begin
      if (elig[i]) begin
        sel_vld = 1'b1;
        sel_idx = IW'(i);
      end
    end
    sel_over = sel_vld & pend[sel_idx];
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store #(
  parameter int NUM_MBX = 8,
  parameter int IW      = $clog2(NUM_MBX)
) (
  input  logic          clk,
  input  logic          fr_we,
  input  logic [IW-1:0] fr_idx,
  input  logic [4:0]    fr_ctrl,
  input  logic [31:0]   fr_lo,
  input  logic [31:0]   fr_hi,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [1:0]    sw_sel,
  input  logic [31:0]   sw_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [4:0]    rd_ctrl,
  output logic [31:0]   rd_lo,
  output logic [31:0]   rd_hi
);
  logic [4:0]  ctrl_mem [NUM_MBX];
  logic [31:0] lo_mem   [NUM_MBX];
  logic [31:0] hi_mem   [NUM_MBX];

  // single write port per memory, frame store first
  always_ff @(posedge clk) begin
    if (fr_we) begin
      ctrl_mem[fr_idx] <= fr_ctrl;
      lo_mem[fr_idx]   <= fr_lo;
      hi_mem[fr_idx]   <= fr_hi;
    end else if (sw_we) begin
      case (sw_sel)
        2'd0:    ctrl_mem[sw_idx] <= sw_data[4:0];
        2'd1:    lo_mem[sw_idx]   <= sw_data;
        default: hi_mem[sw_idx]   <= sw_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_ctrl <= ctrl_mem[rd_idx];
      rd_lo   <= lo_mem[rd_idx];
      rd_hi   <= hi_mem[rd_idx];
    end
  end
endmodule

// File: rtl/rxmb_alloc.sv
module rxmb_alloc
  import rxmb_pkg::*;
#(
  parameter int NUM_MBX = 8,
  parameter int ADDR_W  = $clog2(NUM_MBX) + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_valid,
  input  logic               frm_ext,
  input  logic               frm_rtr,
  input  logic [28:0]        frm_id,
  input  logic [3:0]         frm_dlc,
  input  logic [63:0]        frm_data,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_MBX-1:0] rx_pend,
  output logic               lost_irq
);
  localparam int IW = $clog2(NUM_MBX);

  logic [NUM_MBX-1:0][31:0] id_q, lam_q;
  logic [NUM_MBX-1:0][5:0]  prio_q;
  logic [NUM_MBX-1:0]       en_q, pend_q, prot_q, lost_q;
  logic                     flag_q;

  // address decode
  logic          glb;
  logic [2:0]    fld;
  logic [IW-1:0] mbx;
  assign glb = reg_addr[ADDR_W-1];
  assign fld = reg_addr[2:0];
  assign mbx = reg_addr[3 +: IW];

  logic mwr, gwr;
  assign mwr = reg_wr & ~glb;
  assign gwr = reg_wr & glb;

  // frame acceptance
  logic [28:0]        f_word;
  logic [NUM_MBX-1:0] hit;
  logic               sel_vld, sel_over, store_we;
  logic [IW-1:0]      sel_idx;
  assign f_word = id_field(frm_ext, frm_id);

  rxmb_match #(.NUM_MBX(NUM_MBX)) match_i (
    .f_ext(frm_ext), .f_word(f_word), .en(en_q),
    .id_w(id_q), .lam_w(lam_q), .hit(hit)
  );

  rxmb_select #(.NUM_MBX(NUM_MBX), .IW(IW)) select_i (
    .hit(hit), .pend(pend_q), .prot(prot_q),
    .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_over(sel_over)
  );

  assign store_we = frm_valid & sel_vld;

  logic [NUM_MBX-1:0] store_1h;
  assign store_1h = store_we ? (NUM_MBX'(1) << sel_idx) : '0;

  // per-mailbox filter and priority registers
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q   <= '0;
      lam_q  <= '0;
      prio_q <= '0;
    end else begin
      for (int i = 0; i < NUM_MBX; i++) begin
        if (store_1h[i])
          id_q[i] <= {frm_ext, id_q[i][30:29], f_word};
        else if (mwr && fld == F_ID && mbx == IW'(i))
          id_q[i] <= reg_wdata;
        if (mwr && fld == F_LAM && mbx == IW'(i))
          lam_q[i] <= reg_wdata;
        if (mwr && fld == F_CTRL && mbx == IW'(i))
          prio_q[i] <= reg_wdata[13:8];
      end
    end
  end

  // global vectors: writes of 1 clear, stores set and win
  logic [NUM_MBX-1:0] wclr;
  assign wclr = reg_wdata[NUM_MBX-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prot_q <= '0;
      pend_q <= '0;
      lost_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (gwr && fld == G_EN)   en_q   <= wclr;
      if (gwr && fld == G_PROT) prot_q <= wclr;
      pend_q <= (pend_q & ~((gwr && fld == G_PEND) ? wclr : '0)) | store_1h;
      lost_q <= (lost_q & ~((gwr && fld == G_LOST) ? wclr : '0))
              | (sel_over ? store_1h : '0);
      if (store_we && sel_over)
        flag_q <= 1'b1;
      else if (gwr && fld == G_FLAG && reg_wdata[0])
        flag_q <= 1'b0;
    end
  end

  // frame payload storage
  logic        sw_ram_we;
  logic [1:0]  sw_sel;
  logic [4:0]  ram_ctrl;
  logic [31:0] ram_lo, ram_hi;
  assign sw_ram_we = mwr && (fld == F_CTRL || fld == F_DLO || fld == F_DHI);
  assign sw_sel    = (fld == F_CTRL) ? 2'd0 : (fld == F_DLO) ? 2'd1 : 2'd2;

  rxmb_store #(.NUM_MBX(NUM_MBX), .IW(IW)) store_i (
    .clk(clk),
    .fr_we(store_we), .fr_idx(sel_idx), .fr_ctrl({frm_rtr, frm_dlc}),
    .fr_lo(frm_data[63:32]), .fr_hi(frm_data[31:0]),
    .sw_we(sw_ram_we), .sw_idx(mbx), .sw_sel(sw_sel), .sw_data(reg_wdata),
    .rd_en(reg_rd & ~glb), .rd_idx(mbx),
    .rd_ctrl(ram_ctrl), .rd_lo(ram_lo), .rd_hi(ram_hi)
  );

  // read path
  logic [31:0] rd_val, rd_flop_q;
  logic        rd_glb_q;
  logic [2:0]  rd_fld_q;

  always_comb begin
    rd_val = '0;
    if (glb) begin
      case (fld)
        G_EN:   rd_val = 32'(en_q);
        G_PEND: rd_val = 32'(pend_q);
        G_LOST: rd_val = 32'(lost_q);
        G_PROT: rd_val = 32'(prot_q);
        G_FLAG: rd_val = {31'h0, flag_q};
        default: rd_val = '0;
      endcase
    end else begin
      case (fld)
        F_ID:   rd_val = id_q[mbx];
        F_CTRL: rd_val = {18'h0, prio_q[mbx], 8'h0};
        F_LAM:  rd_val = lam_q[mbx];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_flop_q <= '0;
      rd_glb_q  <= 1'b1;
      rd_fld_q  <= '0;
    end else if (reg_rd) begin
      rd_flop_q <= rd_val;
      rd_glb_q  <= glb;
      rd_fld_q  <= fld;
    end
  end

  always_comb begin
    reg_rdata = rd_flop_q;
    if (!rd_glb_q) begin
      if (rd_fld_q == F_CTRL)     reg_rdata = rd_flop_q | {27'h0, ram_ctrl};
      else if (rd_fld_q == F_DLO) reg_rdata = ram_lo;
      else if (rd_fld_q == F_DHI) reg_rdata = ram_hi;
    end
  end

  assign rx_pend  = pend_q;
  assign lost_irq = flag_q;

  // R1: the target accepts the frame and is enabled
  p_target_hit_r1: assert property (@(posedge clk) disable iff (rst)
    store_we |-> (hit[sel_idx] && en_q[sel_idx]));

  // R6: a protected full mailbox is never reused
  p_no_protected_overwrite_r6: assert property (@(posedge clk) disable iff (rst)
    store_we |-> !(prot_q[sel_idx] && pend_q[sel_idx]));

  // R5: the stored mailbox shows pending one cycle later
  p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
    store_we |=> pend_q[$past(sel_idx)]);

  // R5: at most one pending bit is gained per cycle
  p_one_new_pend_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(pend_q & ~$past(pend_q)) <= 1);

  // R7: the interrupt flag only rises after an overwrite of a pending mailbox
  p_lost_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(store_we && pend_q[sel_idx]));

  // R8: a refused frame leaves the flag vectors alone
  p_discard_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !store_we && !reg_wr) |=> ($stable(pend_q) && $stable(lost_q) && $stable(flag_q)));
endmodule

// File: tb/rxmb_alloc_tb_top.sv
module rxmb_alloc_tb_top;
  localparam int N  = 8;
  localparam int AW = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] rx_pend;
  logic        lost_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rxmb_alloc #(.NUM_MBX(N)) dut_i (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ext(frm_ext),
    .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_pend(rx_pend), .lost_irq(lost_irq)
  );

  // behavioural reference state
  logic [31:0] m_id [N], m_lam [N], m_lo [N], m_hi [N];
  logic [5:0]  m_prio [N];
  logic [4:0]  m_ctrl [N];
  logic [N-1:0] m_en, m_pend, m_prot, m_lost;
  logic        m_flag;

  function automatic bit accepts(int m, bit ext, logic [28:0] id);
    logic [31:0] w = m_id[m];
    logic [31:0] k = m_lam[m];
    if (!w[30]) begin
      if (w[31] != ext) return 0;
      if (ext) return w[28:0] == id;
      return w[28:18] == id[10:0];
    end
    if (!k[31] && w[31] != ext) return 0;
    if (ext) begin
      for (int b = 0; b < 29; b++) if (!k[b] && w[b] != id[b]) return 0;
    end else begin
      for (int b = 0; b < 11; b++) if (!k[18+b] && w[18+b] != id[b]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < N; m++) begin
        m_id[m] = '0; m_lam[m] = '0; m_prio[m] = '0;
        m_lo[m] = '0; m_hi[m] = '0; m_ctrl[m] = '0;
      end
      m_en = '0; m_pend = '0; m_prot = '0; m_lost = '0; m_flag = 1'b0;
    end else begin
      int tgt;
      logic [N-1:0] old_pend;
      tgt = -1;
      old_pend = m_pend;
      if (frm_valid) begin
        for (int m = N - 1; m >= 0; m--)
          if (tgt < 0 && m_en[m] && accepts(m, frm_ext, frm_id) && !(m_prot[m] && m_pend[m]))
            tgt = m;
      end
      if (reg_wr) begin
        int mm;
        int ff;
        mm = int'(reg_addr[5:3]);
        ff = int'(reg_addr[2:0]);
        if (reg_addr[6]) begin
          case (ff)
            0: m_en = reg_wdata[N-1:0];
            1: m_pend = m_pend & ~reg_wdata[N-1:0];
            2: m_lost = m_lost & ~reg_wdata[N-1:0];
            3: m_prot = reg_wdata[N-1:0];
            4: if (reg_wdata[0]) m_flag = 1'b0;
            default: ;
          endcase
        end else begin
          case (ff)
            0: m_id[mm] = reg_wdata;
            1: begin m_prio[mm] = reg_wdata[13:8]; if (tgt < 0) m_ctrl[mm] = reg_wdata[4:0]; end
            2: if (tgt < 0) m_lo[mm] = reg_wdata;
            3: if (tgt < 0) m_hi[mm] = reg_wdata;
            4: m_lam[mm] = reg_wdata;
            default: ;
          endcase
        end
      end
      if (tgt >= 0) begin
        m_id[tgt] = {frm_ext, m_id[tgt][30:29], frm_ext ? frm_id : {frm_id[10:0], 18'h0}};
        m_ctrl[tgt] = {frm_rtr, frm_dlc};
        m_lo[tgt] = frm_data[63:32];
        m_hi[tgt] = frm_data[31:0];
        if (old_pend[tgt]) begin m_lost[tgt] = 1'b1; m_flag = 1'b1; end
        m_pend[tgt] = 1'b1;
      end
    end
  end

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    int mm = int'(a[5:3]);
    if (a[6]) begin
      case (a[2:0])
        3'd0: return 32'(m_en);
        3'd1: return 32'(m_pend);
        3'd2: return 32'(m_lost);
        3'd3: return 32'(m_prot);
        3'd4: return {31'h0, m_flag};
        default: return '0;
      endcase
    end
    case (a[2:0])
      3'd0: return m_id[mm];
      3'd1: return {18'h0, m_prio[mm], 3'h0, m_ctrl[mm]};
      3'd2: return m_lo[mm];
      3'd3: return m_hi[mm];
      3'd4: return m_lam[mm];
      default: return '0;
    endcase
  endfunction

  // per-clock comparison of the outputs (R5 pending, R7 flag)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rx_pend !== m_pend || lost_irq !== m_flag) begin
        errors++;
        $display("FAIL R5/R7 outputs: pend=%h flag=%b expected pend=%h flag=%b",
                 rx_pend, lost_irq, m_pend, m_flag);
      end
    end
  end

  function automatic logic [AW-1:0] ma(int m, int f);
    return {1'b0, 3'(m), 3'(f)};
  endfunction
  function automatic logic [AW-1:0] ga(int f);
    return {1'b1, 3'b000, 3'(f)};
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp = model_read(a);
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic rx(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_dlc = dlc; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    rd_chk(ga(0), "R10 enable");
    rd_chk(ga(1), "R10 pending");
    rd_chk(ma(7, 0), "R10 id");
    rd_chk(ga(4), "R10 flag");

    // configuration through the register port (R9)
    for (int m = 0; m < N; m++) begin
      wr(ma(m, 1), 32'h0); wr(ma(m, 2), 32'h0); wr(ma(m, 3), 32'h0);
    end
    wr(ma(7, 0), 32'h248C_0000); wr(ma(7, 1), 32'h0000_2A1F);
    wr(ma(6, 0), 32'h81AB_CDEF);
    for (int m = 3; m <= 5; m++) begin
      wr(ma(m, 0), 32'h4000_0000); wr(ma(m, 4), 32'hFFFF_FFFF);
    end
    wr(ma(2, 0), 32'h5C00_0000); wr(ma(2, 4), 32'h63FF_FFFF);
    wr(ga(0), 32'h0000_00F7);
    rd_chk(ga(0), "R9 enable");
    rd_chk(ma(2, 4), "R9 mask");

    // R2 standard exact match and R4 content
    rx(0, 0, 29'h123, 4'd8, 64'h0011_2233_4455_6677);
    rd_chk(ma(7, 0), "R4 id word");
    rd_chk(ma(7, 1), "R4 control word");
    rd_chk(ma(7, 2), "R4 data low");
    rd_chk(ma(7, 3), "R4 data high");

    // R2 extended exact match, remote frame
    rx(1, 1, 29'h1ABC_DEF, 4'd3, 64'hA1A2_A3A4_A5A6_A7A8);
    rd_chk(ma(6, 0), "R2 extended id");
    rd_chk(ma(6, 1), "R4 remote control");

    // R3 accept-all mailbox takes a non-matching standard frame
    rx(0, 0, 29'h124, 4'd2, 64'h1111_2222_3333_4444);
    rd_chk(ma(5, 0), "R3 accept-all id");
    rd_chk(ga(1), "R1 pending after three");

    // R6 protected full mailbox passes to lower one
    wr(ga(3), 32'h20);
    rx(0, 0, 29'h055, 4'd1, 64'h5500_0000_0000_0000);
    rd_chk(ma(5, 2), "R6 protected data kept");
    rd_chk(ma(4, 2), "R6 lower mailbox data");

    // R7 overwrite of unprotected full mailbox
    rx(0, 0, 29'h056, 4'd1, 64'h5600_0000_0000_0000);
    rd_chk(ga(2), "R7 lost bit");
    rd_chk(ga(4), "R7 flag");
    rd_chk(ma(4, 2), "R7 newest data");
    wr(ga(2), 32'h10); wr(ga(4), 32'h1);
    rd_chk(ga(2), "R7 lost cleared");
    rd_chk(ga(4), "R7 flag cleared");

    // R5 clear by writing one, zero has no effect
    wr(ga(1), 32'h0);
    rd_chk(ga(1), "R5 zero write");
    wr(ga(1), 32'h80);
    rd_chk(ga(1), "R5 one write");

    // R1 disabled mailbox skipped, R3 partial mask
    wr(ga(3), 32'h30);
    rx(0, 0, 29'h7FF, 4'd4, 64'hDEAD_BEEF_0000_0000);
    rd_chk(ma(2, 0), "R3 masked id");
    rd_chk(ma(2, 2), "R1 disabled skipped");

    // R8 IDE mismatch under mask, nothing takes it
    rx(1, 0, 29'h1FFF_FFFF, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(ga(1), "R8 pending unchanged");
    rd_chk(ma(2, 3), "R8 data unchanged");
    // R3 masked identifier bits compared
    rx(0, 0, 29'h0FF, 4'd8, 64'h1234_5678_9ABC_DEF0);
    rd_chk(ma(2, 2), "R3 mask mismatch");

    // R6 everything eligible protected and full: dropped
    wr(ga(3), 32'h34);
    rx(0, 0, 29'h7AA, 4'd8, 64'h7777_7777_7777_7777);
    rd_chk(ma(2, 2), "R6 dropped frame");
    rd_chk(ga(2), "R6 no lost");

    // R2 exact standard id zero in a low mailbox
    rx(0, 0, 29'h000, 4'd5, 64'h0102_0304_0506_0708);
    rd_chk(ma(1, 0), "R2 low mailbox id");
    rd_chk(ma(1, 3), "R4 low mailbox high word");

    // R5 store and clear of the same bit collide: set wins
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = 1'b0; frm_rtr = 1'b0; frm_id = 29'h123;
    frm_dlc = 4'd2; frm_data = 64'hCAFE_0000_0000_0000;
    reg_wr = 1'b1; reg_addr = ga(1); reg_wdata = 32'h80;
    @(negedge clk);
    frm_valid = 1'b0; reg_wr = 1'b0;
    rd_chk(ga(1), "R5 set beats clear");

    // final sweep of all mailbox words
    for (int m = 0; m < N; m++)
      for (int f = 0; f < 5; f++) rd_chk(ma(m, f), "R9 sweep");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule